// File: doc/BRIEF.md
# Multi-Epoch Annealing Controller

This block steers a simulated-annealing search over two binary vectors, a row vector and a column vector. The energy is computed by an outside evaluator, for example an in-memory vector-matrix-vector engine. On each iteration the controller shows a candidate pair of vectors and raises an energy request. It captures the signed energy that comes back and decides whether to accept the candidate. It keeps the lowest-energy pair seen so far, then builds the next candidate by flipping a few pseudo-randomly chosen bits.

The search runs in epochs. Each epoch starts at the initial temperature, and the temperature falls geometrically with every decision. An epoch ends when enough results have landed within a tolerance band of the last accepted energy. The next epoch then restarts from the best pair found so far, at full temperature again. The run ends after a programmed number of energy evaluations. A one-cycle done pulse follows, and the best vectors and energy stay frozen.

Top module: `anneal_ctrl`

## Requirements
- R1: After reset and before any start, done and energyReq are 0, and curRow, curCol, bestRow, bestCol and bestEnergy are all zero.
- R2: A start pulse while idle loads initRow and initCol as the candidate and raises energyReq. energyReq stays high, and curRow and curCol stay unchanged, until the cycle in which energyValid is sampled high. That cycle captures energyIn.
- R3: The first result of a run is accepted unconditionally. It becomes the accepted energy and the best energy. A later result whose difference d = energy − accepted energy is negative is always accepted, and it clears the trap count.
- R4: On every acceptance other than the first, bestRow, bestCol and bestEnergy are replaced only when the new energy is strictly lower than bestEnergy. bestEnergy never increases within a run.
- R5: A result with 0 ≤ d ≤ cfgTol is rejected. The candidate returns to the accepted pair and the trap count increments.
- R6: A result with d > cfgTol is accepted when r < t. Here r is the low 8 bits of the random register in the decision cycle. t = T − d when d < T and 0 otherwise, where T is the temperature before cooling. A rejected candidate returns to the accepted pair.
- R7: The temperature is loaded with cfgTempInit at start, with 0 treated as 1. After each decision that does not restart the epoch, it becomes T − (T >> cfgCoolShift), with a floor of 1.
- R8: When a rejection under R5 brings the incremented trap count to at least cfgTrapMax, the epoch restarts. The candidate, the accepted pair and the accepted energy become the best pair and bestEnergy, the trap count clears, and the temperature reloads as in R7.
- R9: The random register is a 32-bit shift-left register with feedback bit = b31^b21^b1^b0. It is loaded with cfgSeed at start, with 0 treated as 1, and steps once in each decision cycle and once in each flip cycle. After a decision that does not end the run, F = cfgFlipCount bit flips follow, one per cycle, with F clamped to the range 1..4. Each flip toggles position p = (low 16 random bits) mod (ROWS+COLS). p < ROWS selects curRow[p]; otherwise it selects curCol[p−ROWS].
- R10: When the decision count reaches cfgIterBudget (0 acts as 1), no further flip or request follows. done is high for exactly the next cycle, and the best outputs then hold steady. This holds even if the same decision also restarts an epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| cfgSeed | input | 32 | Random register seed |
| cfgTempInit | input | TW | Initial temperature per epoch |
| cfgCoolShift | input | 4 | Cooling shift amount |
| cfgTol | input | EW | Stagnation tolerance band |
| cfgTrapMax | input | CW | Trap count that ends an epoch |
| cfgIterBudget | input | IW | Total energy evaluations per run |
| cfgFlipCount | input | 3 | Bits flipped per proposal (clamped 1..4) |
| initRow | input | ROWS | Starting row vector |
| initCol | input | COLS | Starting column vector |
| energyReq | output | 1 | Energy wanted for curRow/curCol |
| energyValid | input | 1 | energyIn is valid |
| energyIn | input | EW | Signed energy result |
| curRow | output | ROWS | Candidate row vector |
| curCol | output | COLS | Candidate column vector |
| bestRow | output | ROWS | Best row vector |
| bestCol | output | COLS | Best column vector |
| bestEnergy | output | EW | Signed best energy |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The epoch restart and the end of the run can fall on the same decision. In that case the restart must still leave the best pair intact, and the budget must suppress any further flip or request. The bench provokes this by setting a trap limit of 1 and a wide tolerance, so that nearly every non-improving result restarts the epoch, with budgets that end on arbitrary iterations. It judges the outcome by comparing every presented candidate and the final best vectors and energy with an iteration-level model. It also checks that done pulses exactly two cycles after the final result and that no request follows.

// File: rtl/anneal_pkg.sv
package anneal_pkg;
  typedef struct packed {
    logic load;
    logic capture;
    logic decide;
    logic flip;
  } strobe_t;

  function automatic logic [2:0] clampFlips(input logic [2:0] n);
    if (n == 3'd0) return 3'd1;
    if (n > 3'd4) return 3'd4;
    return n;
  endfunction
endpackage

// File: rtl/anneal_ctrl_fsm.sv
module anneal_ctrl_fsm
  import anneal_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          energyValid,
  input  logic [IW-1:0] cfgIterBudget,
  input  logic [2:0]    cfgFlipCount,
  output strobe_t       stb,
  output logic          energyReq,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_DECIDE, S_FLIP, S_FIN} state_t;

  state_t        state;
  logic [IW-1:0] iterCnt;
  logic [IW:0]   iterNext;
  logic [2:0]    flipCnt;
  logic [2:0]    flipN;
  logic          lastIter;

  assign flipN    = clampFlips(cfgFlipCount);
  assign iterNext = {1'b0, iterCnt} + 1'b1;
  assign lastIter = iterNext >= {1'b0, cfgIterBudget};

  assign energyReq   = (state == S_REQ);
  assign done        = (state == S_FIN);
  assign stb.load    = (state == S_IDLE) && start;
  assign stb.capture = (state == S_REQ) && energyValid;
  assign stb.decide  = (state == S_DECIDE);
  assign stb.flip    = (state == S_FLIP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
      flipCnt <= 3'd1;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          iterCnt <= '0;
        end
        S_REQ: if (energyValid) state <= S_DECIDE;
        S_DECIDE: begin
          iterCnt <= iterNext[IW-1:0];
          flipCnt <= 3'd1;
          state   <= lastIter ? S_FIN : S_FLIP;
        end
        S_FLIP: begin
          if (flipCnt >= flipN) state <= S_REQ;
          else flipCnt <= flipCnt + 3'd1;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/anneal_datapath.sv
module anneal_datapath
  import anneal_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int EW   = 16,
  parameter int TW   = 8,
  parameter int CW   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [31:0]          cfgSeed,
  input  logic [TW-1:0]        cfgTempInit,
  input  logic [3:0]           cfgCoolShift,
  input  logic [EW-1:0]        cfgTol,
  input  logic [CW-1:0]        cfgTrapMax,
  input  logic [ROWS-1:0]      initRow,
  input  logic [COLS-1:0]      initCol,
  input  logic signed [EW-1:0] energyIn,
  output logic [ROWS-1:0]      curRow,
  output logic [COLS-1:0]      curCol,
  output logic [ROWS-1:0]      bestRow,
  output logic [COLS-1:0]      bestCol,
  output logic signed [EW-1:0] bestEnergy
);
  localparam int NV = ROWS + COLS;

  logic [31:0]          lfsr;
  logic [ROWS-1:0]      accRow;
  logic [COLS-1:0]      accCol;
  logic signed [EW-1:0] accE, eNew;
  logic [TW-1:0]        temp;
  logic [CW-1:0]        trap;
  logic                 first;

  logic signed [EW:0]   diff, tolWide, tempWide;
  logic                 isLower, isFlat, isWorse, accept, restart, bestWin;
  logic [TW-1:0]        thresh, tempLoad, cooled, coolRaw;
  logic [CW:0]          trapInc;
  logic [15:0]          pos;
  logic [ROWS-1:0]      rowMask;
  logic [COLS-1:0]      colMask;
  logic [31:0]          lfsrStep;

  assign lfsrStep = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  assign pos      = lfsr[15:0] % 16'(NV);

  for (genvar i = 0; i < ROWS; i++) begin : g_rowMask
    assign rowMask[i] = (pos == 16'(i));
  end
  for (genvar j = 0; j < COLS; j++) begin : g_colMask
    assign colMask[j] = (pos == 16'(ROWS + j));
  end

  assign diff     = {eNew[EW-1], eNew} - {accE[EW-1], accE};
  assign tolWide  = signed'({1'b0, cfgTol});
  assign tempWide = signed'({{(EW + 1 - TW){1'b0}}, temp});
  assign isLower  = diff < 0;
  assign isFlat   = !isLower && (diff <= tolWide);
  assign isWorse  = !isLower && !isFlat;
  assign thresh   = (diff >= tempWide) ? '0 : temp - diff[TW-1:0];
  assign accept   = first || isLower || (isWorse && (lfsr[TW-1:0] < thresh));
  assign trapInc  = {1'b0, trap} + 1'b1;
  assign restart  = !first && isFlat && (trapInc >= {1'b0, cfgTrapMax});
  assign bestWin  = accept && (first || (eNew < bestEnergy));

  assign tempLoad = (cfgTempInit == '0) ? TW'(1) : cfgTempInit;
  assign coolRaw  = temp - (temp >> cfgCoolShift);
  assign cooled   = (coolRaw == '0) ? TW'(1) : coolRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr       <= 32'd1;
      curRow     <= '0;
      curCol     <= '0;
      accRow     <= '0;
      accCol     <= '0;
      accE       <= '0;
      eNew       <= '0;
      bestRow    <= '0;
      bestCol    <= '0;
      bestEnergy <= '0;
      temp       <= TW'(1);
      trap       <= '0;
      first      <= 1'b0;
    end else begin
      if (stb.load) begin
        lfsr   <= (cfgSeed == 32'd0) ? 32'd1 : cfgSeed;
        curRow <= initRow;
        curCol <= initCol;
        temp   <= tempLoad;
        trap   <= '0;
        first  <= 1'b1;
      end
      if (stb.capture) eNew <= energyIn;
      if (stb.decide) begin
        lfsr  <= lfsrStep;
        first <= 1'b0;
        if (restart) begin
          curRow <= bestRow;
          curCol <= bestCol;
          accRow <= bestRow;
          accCol <= bestCol;
          accE   <= bestEnergy;
          temp   <= tempLoad;
          trap   <= '0;
        end else begin
          temp <= cooled;
          if (isFlat && !first) trap <= trapInc[CW-1:0];
          else if (isLower) trap <= '0;
          if (accept) begin
            accRow <= curRow;
            accCol <= curCol;
            accE   <= eNew;
          end else begin
            curRow <= accRow;
            curCol <= accCol;
          end
        end
        if (bestWin) begin
          bestRow    <= curRow;
          bestCol    <= curCol;
          bestEnergy <= eNew;
        end
      end
      if (stb.flip) begin
        lfsr   <= lfsrStep;
        curRow <= curRow ^ rowMask;
        curCol <= curCol ^ colMask;
      end
    end
  end
endmodule

// File: rtl/anneal_ctrl.sv
module anneal_ctrl
  import anneal_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int EW   = 16,
  parameter int TW   = 8,
  parameter int CW   = 8,
  parameter int IW   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [31:0]          cfgSeed,
  input  logic [TW-1:0]        cfgTempInit,
  input  logic [3:0]           cfgCoolShift,
  input  logic [EW-1:0]        cfgTol,
  input  logic [CW-1:0]        cfgTrapMax,
  input  logic [IW-1:0]        cfgIterBudget,
  input  logic [2:0]           cfgFlipCount,
  input  logic [ROWS-1:0]      initRow,
  input  logic [COLS-1:0]      initCol,
  output logic                 energyReq,
  input  logic                 energyValid,
  input  logic signed [EW-1:0] energyIn,
  output logic [ROWS-1:0]      curRow,
  output logic [COLS-1:0]      curCol,
  output logic [ROWS-1:0]      bestRow,
  output logic [COLS-1:0]      bestCol,
  output logic signed [EW-1:0] bestEnergy,
  output logic                 done
);
  strobe_t stb;

  anneal_ctrl_fsm #(.IW(IW)) u_fsm (
    .clk(clk), .rstN(rstN), .start(start), .energyValid(energyValid),
    .cfgIterBudget(cfgIterBudget), .cfgFlipCount(cfgFlipCount),
    .stb(stb), .energyReq(energyReq), .done(done)
  );

  anneal_datapath #(.ROWS(ROWS), .COLS(COLS), .EW(EW), .TW(TW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgSeed(cfgSeed),
    .cfgTempInit(cfgTempInit), .cfgCoolShift(cfgCoolShift), .cfgTol(cfgTol),
    .cfgTrapMax(cfgTrapMax), .initRow(initRow), .initCol(initCol),
    .energyIn(energyIn), .curRow(curRow), .curCol(curCol),
    .bestRow(bestRow), .bestCol(bestCol), .bestEnergy(bestEnergy)
  );
endmodule

// File: rtl/anneal_ctrl_chk.sv
module anneal_ctrl_chk
  import anneal_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int EW   = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input strobe_t              stb,
  input logic                 energyReq,
  input logic                 energyValid,
  input logic                 done,
  input logic [ROWS-1:0]      curRow,
  input logic [COLS-1:0]      curCol,
  input logic [ROWS-1:0]      bestRow,
  input logic [COLS-1:0]      bestCol,
  input logic signed [EW-1:0] bestEnergy
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (stb.load) armed <= 1'b0;
    else if (stb.decide) armed <= 1'b1;
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    energyReq && !energyValid |=> energyReq);
  // R2
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    energyReq && !energyValid |=> $stable(curRow) && $stable(curCol));
  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && !stb.load |=> bestEnergy <= $past(bestEnergy));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !energyReq);
  // R10
  best_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(bestRow) && $stable(bestCol) && $stable(bestEnergy));
endmodule

bind anneal_ctrl anneal_ctrl_chk #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .energyReq(energyReq),
  .energyValid(energyValid), .done(done), .curRow(curRow), .curCol(curCol),
  .bestRow(bestRow), .bestCol(bestCol), .bestEnergy(bestEnergy)
);

// File: tb/anneal_ctrl_tb.sv
module anneal_ctrl_tb;
  localparam int ROWS = 8, COLS = 8, EW = 16, TW = 8, CW = 8, IW = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] cfgSeed = '0;
  logic [TW-1:0] cfgTempInit = '0;
  logic [3:0] cfgCoolShift = '0;
  logic [EW-1:0] cfgTol = '0;
  logic [CW-1:0] cfgTrapMax = '0;
  logic [IW-1:0] cfgIterBudget = '0;
  logic [2:0] cfgFlipCount = '0;
  logic [ROWS-1:0] initRow = '0;
  logic [COLS-1:0] initCol = '0;
  logic energyReq, energyValid = 1'b0, done;
  logic signed [EW-1:0] energyIn = '0;
  logic [ROWS-1:0] curRow, bestRow;
  logic [COLS-1:0] curCol, bestCol;
  logic signed [EW-1:0] bestEnergy;

  always #2 clk = ~clk;

  anneal_ctrl #(.ROWS(ROWS), .COLS(COLS), .EW(EW), .TW(TW), .CW(CW), .IW(IW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgSeed(cfgSeed),
    .cfgTempInit(cfgTempInit), .cfgCoolShift(cfgCoolShift), .cfgTol(cfgTol),
    .cfgTrapMax(cfgTrapMax), .cfgIterBudget(cfgIterBudget),
    .cfgFlipCount(cfgFlipCount), .initRow(initRow), .initCol(initCol),
    .energyReq(energyReq), .energyValid(energyValid), .energyIn(energyIn),
    .curRow(curRow), .curCol(curCol), .bestRow(bestRow), .bestCol(bestCol),
    .bestEnergy(bestEnergy), .done(done)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int q [ROWS][COLS];

  // reference model state
  logic [31:0] mL;
  logic [ROWS-1:0] mCurR, mAccR, mBestR;
  logic [COLS-1:0] mCurC, mAccC, mBestC;
  int mAccE, mBestE, mTemp, mTrap, mTempInit;
  bit mFirst;

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int energyOf(input logic [ROWS-1:0] r, input logic [COLS-1:0] c);
    int e = 0;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        if (r[i] && c[j]) e += q[i][j];
    return e;
  endfunction

  function automatic logic [31:0] stepL(input logic [31:0] l);
    return {l[30:0], l[31] ^ l[21] ^ l[1] ^ l[0]};
  endfunction

  task automatic modelDecide(input int e, input int tol, input int trapMax, input int shift);
    int d, th, t;
    bit acc, flat, worse, rst;
    d = e - mAccE;
    flat = !mFirst && d >= 0 && d <= tol;
    worse = !mFirst && d > tol;
    th = (d >= mTemp) ? 0 : mTemp - d;
    acc = mFirst || d < 0 || (worse && int'(mL[7:0]) < th);
    rst = flat && (mTrap + 1 >= trapMax);
    mL = stepL(mL);
    if (acc && (mFirst || e < mBestE)) begin
      mBestR = mCurR; mBestC = mCurC; mBestE = e;
    end
    if (rst) begin
      mCurR = mBestR; mCurC = mBestC; mAccR = mBestR; mAccC = mBestC;
      mAccE = mBestE; mTemp = mTempInit; mTrap = 0;
    end else begin
      t = mTemp - (mTemp >> shift);
      mTemp = (t < 1) ? 1 : t;
      if (flat) mTrap++;
      else if (!mFirst && d < 0) mTrap = 0;
      if (acc) begin
        mAccR = mCurR; mAccC = mCurC; mAccE = e;
      end else begin
        mCurR = mAccR; mCurC = mAccC;
      end
    end
    mFirst = 0;
  endtask

  task automatic modelFlips(input int n);
    int p;
    for (int k = 0; k < n; k++) begin
      p = int'(mL[15:0]) % (ROWS + COLS);
      if (p < ROWS) mCurR[p] = ~mCurR[p];
      else mCurC[p - ROWS] = ~mCurC[p - ROWS];
      mL = stepL(mL);
    end
  endtask

  task automatic runOnce(input logic [31:0] seed, input int tInit, input int shift,
                         input int tol, input int trapMax, input int budget,
                         input int flips, input logic [ROWS-1:0] ir,
                         input logic [COLS-1:0] ic, input string tag);
    int nf, e, dly, eff;
    @(negedge clk);
    cfgSeed = seed; cfgTempInit = TW'(tInit); cfgCoolShift = 4'(shift);
    cfgTol = EW'(tol); cfgTrapMax = CW'(trapMax); cfgIterBudget = IW'(budget);
    cfgFlipCount = 3'(flips); initRow = ir; initCol = ic;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mL = (seed == 0) ? 32'd1 : seed;
    mCurR = ir; mCurC = ic; mAccR = ir; mAccC = ic; mAccE = 0;
    mTempInit = (tInit == 0) ? 1 : tInit; mTemp = mTempInit; mTrap = 0; mFirst = 1;
    nf = (flips == 0) ? 1 : (flips > 4 ? 4 : flips);
    eff = (budget == 0) ? 1 : budget;
    for (int it = 0; it < eff; it++) begin
      while (!energyReq) @(negedge clk);
      // R2 R9: presented candidate matches the model
      check({tag, " R9 curRow"}, curRow, mCurR);
      check({tag, " R9 curCol"}, curCol, mCurC);
      e = energyOf(mCurR, mCurC);
      dly = $urandom_range(0, 3);
      repeat (dly) @(negedge clk);
      energyIn = EW'(e); energyValid = 1'b1;
      @(negedge clk);
      energyValid = 1'b0;
      modelDecide(e, tol, trapMax, shift);
      if (it < eff - 1) modelFlips(nf);
    end
    @(negedge clk);
    // R10: done two cycles after the final result, no request
    check({tag, " R10 done"}, done, 1);
    check({tag, " R10 req low"}, energyReq, 0);
    @(negedge clk);
    check({tag, " R10 done once"}, done, 0);
    // R4 R8: best results
    check({tag, " R4 bestRow"}, bestRow, mBestR);
    check({tag, " R4 bestCol"}, bestCol, mBestC);
    check({tag, " R4 bestEnergy"}, bestEnergy, mBestE);
    repeat (3) @(negedge clk);
    check({tag, " R10 best held"}, bestEnergy, mBestE);
    check({tag, " R10 no request"}, energyReq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'h5eed);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++)
        q[i][j] = $urandom_range(0, 15) - 8;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done, 0);
    check("R1 energyReq", energyReq, 0);
    check("R1 curRow", curRow, 0);
    check("R1 curCol", curCol, 0);
    check("R1 bestEnergy", bestEnergy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", energyReq, 0);
    // R3: budget of one, first result is the best
    runOnce(32'h1234, 50, 3, 2, 4, 1, 2, 8'hA5, 8'h3C, "R3 single");
    // R7 R9: zero seed, zero temperature, flip count saturation
    runOnce(32'h0, 0, 2, 1, 3, 40, 0, 8'h0F, 8'hF0, "R7 zeros");
    runOnce(32'hCAFE, 200, 1, 0, 5, 60, 7, 8'hFF, 8'hFF, "R9 flip4");
    // R8 R10: restart on nearly every stall, budgets ending anywhere
    runOnce(32'hBEEF, 100, 2, 40, 1, 77, 1, 8'h11, 8'h22, "R8 restart");
    runOnce(32'h0BAD, 120, 4, 60, 1, 33, 3, 8'h81, 8'h18, "R8 restart2");
    // R5 R6: hot search with small tolerance
    runOnce(32'h7777, 255, 5, 0, 8, 150, 2, 8'h00, 8'hFF, "R6 hot");
    for (int r = 0; r < 6; r++) begin
      runOnce($urandom, $urandom_range(0, 255), $urandom_range(0, 8),
              $urandom_range(0, 20), $urandom_range(1, 10),
              $urandom_range(1, 200), $urandom_range(0, 7),
              ROWS'($urandom), COLS'($urandom), "R5 random");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule